// File: doc/BRIEF.md
# Reference Pulse Timestamp and Lock Qualifier

This block timestamps every rising edge of an external once-per-second reference pulse against a free-running tick counter. The counter runs on the local base oscillator. The pulse is brought into the base clock domain through a synchroniser and an edge detector. Each detected edge latches a record. The record holds a wide timestamp, which is the counter extended by a count of its own wraps, and a rolling sequence tag that advances on every capture.

Each new record is compared with the one before it. The tick distance between the two is taken modulo the timestamp width, so a wrap of the timestamp between the two captures does no harm. If the two records are consecutive and the distance lies within a parts-per-million band around the nominal base frequency, a lock status is raised and the distance is latched. A distance outside the band drops the lock. A ready flag tells a consumer that a new record is waiting, and the consumer clears it with a read strobe.

Top module: `pps_stamp_unit`

## Requirements
- R1: After reset the base counter (CNT_W bits) is 0. It advances by one on every clock and rolls from all-ones back to 0.
- R2: A separate OVF_W-bit wrap count advances on every counter roll. The timestamp is {wrap count, counter}, which equals the number of clocks since reset modulo 2^(CNT_W+OVF_W).
- R3: A rising edge on `pps_in` yields exactly one record, however long the pulse stays high. The input is sampled through a two-flop synchroniser and an edge detector. If `pps_in` rises before clock edge k, `rec_valid` is high for one cycle after edge k+2, and the recorded timestamp is the value the timestamp held just before edge k+2.
- R4: The sequence tag (SEQ_W bits) is incremented before it is stored. The first record after reset carries 1, and the tag wraps modulo 2^SEQ_W. `rec_data` is packed as {tag, wrap count, counter}, with the tag in the most significant bits.
- R5: A capture that falls in the cycle where the counter rolls stores a wrap count that matches the stored counter value. Counter all-ones goes with the old wrap count. Counter 0 goes with the incremented wrap count.
- R6: The interval between two records is the newer timestamp minus the older one, modulo 2^(CNT_W+OVF_W). It stays correct when the timestamp wraps between the two captures.
- R7: An interval is judged only when a previous record exists and the two tags differ by exactly one modulo 2^SEQ_W. The first record after reset leaves `lock` unchanged.
- R8: The window is NOMINAL_TICKS ± NOMINAL_TICKS·PPM_TOL/10^6 (integer division), with both bounds inclusive. An interval inside the window sets `lock` and loads `interval_ticks`. An interval outside it clears `lock` and leaves `interval_ticks` as it was. Both outputs update on the clock edge after the one that raises `rec_valid`.
- R9: `ready` is set by each capture and cleared by `rd_ack`. When a capture and `rd_ack` fall in the same cycle, the capture wins.
- R10: During and right after reset, `rec_valid`, `rec_data`, `ready`, `lock` and `interval_ticks` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pps_in | input | 1 | Asynchronous reference pulse |
| rd_ack | input | 1 | Consumer read strobe; clears `ready` |
| rec_valid | output | 1 | One-cycle strobe when a new record is latched |
| rec_data | output | SEQ_W+OVF_W+CNT_W | Latest record {tag, wrap count, counter} |
| ready | output | 1 | A new record is waiting to be read |
| lock | output | 1 | Last judged interval was inside the window |
| interval_ticks | output | OVF_W+CNT_W | Last in-window interval in base ticks |

## Verification
The assertions assume that `pps_in` stays high and low for at least two base clocks between transitions, so that every rising edge gives a single clean edge-detect pulse. They also assume that `rd_ack` is a plain level sampled on the clock. The stimulus holds each pulse high for several cycles and keeps consecutive pulses about twenty thousand cycles apart. It changes `pps_in` and `rd_ack` only on falling clock edges.

The bench uses small counter, wrap-count and tag widths, so that timestamp and tag wraps happen within the run. It places each pulse so that the capture lands on an exact target tick: the counter roll, both edges of the window, one tick beyond each edge, and a timestamp wrap between two captures.

// File: rtl/pps_pkg.sv
// Shared constants and helpers for the reference pulse timestamp unit.
package pps_pkg;

    // Scale for parts-per-million arithmetic.
    localparam longint unsigned PPM_SCALE = 64'd1_000_000;

    // Half-width of the acceptance band, in ticks, for a nominal count and a ppm tolerance.
    function automatic longint unsigned band_ticks(input longint unsigned nominal,
                                                   input longint unsigned ppm);
        return (nominal * ppm) / PPM_SCALE;
    endfunction

endpackage

// File: rtl/pps_sync_edge.sv
// Brings an asynchronous pulse into the clock domain and flags its rising edges.
// Assumes: the pulse stays at each level for at least STAGES clocks.
// edge_o is combinational from flops and is high for one cycle per rising edge.
module pps_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic edge_o
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // First synchroniser flop samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= pulse_i;
    end

    // The remaining synchroniser flops shift the sample along.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    // Holds the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign edge_o = chain_q[STAGES-1] & ~last_q;

    // R3: a detected edge never lasts two cycles.
    p_edge_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/pps_ext_counter.sv
// Free-running base counter extended by a wrap count.
// Assumes: one increment per clock, no prescaler.
// ts_o = {wrap count, counter} as registered in the current cycle.
module pps_ext_counter #(
    parameter int CNT_W = 32,
    parameter int OVF_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [CNT_W+OVF_W-1:0] ts_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [OVF_W-1:0] ovf_q;
    logic             roll;

    assign roll = &cnt_q;

    // Counts base ticks, rolling over to zero after all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CNT_W'(1);
    end

    // Counts the rollovers of the base counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    ovf_q <= '0;
        else if (roll) ovf_q <= ovf_q + OVF_W'(1);
    end

    assign ts_o = {ovf_q, cnt_q};

    // R1: the counter steps by one while it is not at all-ones.
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cnt_q) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)) && $stable(ovf_q));

    // R2: a roll returns the counter to zero and advances the wrap count.
    p_roll_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt_q) |=> (cnt_q == '0) && (ovf_q == $past(ovf_q) + OVF_W'(1)));

endmodule

// File: rtl/pps_capture.sv
// Latches the timestamp and a pre-incremented tag on each detected edge.
// Keeps the ready flag for the consumer.
// Assumes: ts_i is the registered timestamp, so counter and wrap count are coherent.
module pps_capture #(
    parameter int TS_W  = 48,
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic [TS_W-1:0]  ts_i,
    input  logic             rd_ack_i,
    output logic             rec_valid_o,
    output logic [TS_W-1:0]  rec_ts_o,
    output logic [SEQ_W-1:0] rec_seq_o,
    output logic             ready_o
);

    logic [TS_W-1:0]  ts_q;
    logic [SEQ_W-1:0] seq_q;
    logic             valid_q;
    logic             ready_q;

    // Stores the timestamp and the advanced tag when an edge is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q  <= '0;
            seq_q <= '0;
        end else if (edge_i) begin
            ts_q  <= ts_i;
            seq_q <= seq_q + SEQ_W'(1);
        end
    end

    // Produces the one-cycle record strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= edge_i;
    end

    // Ready flag: a capture sets it with priority over the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        ready_q <= 1'b0;
        else if (edge_i)   ready_q <= 1'b1;
        else if (rd_ack_i) ready_q <= 1'b0;
    end

    assign rec_valid_o = valid_q;
    assign rec_ts_o    = ts_q;
    assign rec_seq_o   = seq_q;
    assign ready_o     = ready_q;

    // R4: every capture advances the tag by exactly one.
    p_tag_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> rec_seq_o == $past(rec_seq_o) + SEQ_W'(1));

    // R9: a new record is always announced as ready.
    p_ready_on_rec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |-> ready_o);

    // R9: ready only drops after a read strobe.
    p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> $past(rd_ack_i));

endmodule

// File: rtl/pps_interval_qual.sv
// Measures ticks between consecutive records and judges them against a ppm band.
// Assumes: rec_* come from the capture register and change only with rec_valid_i.
// lock and interval update one clock after rec_valid_i.
module pps_interval_qual #(
    parameter int              TS_W          = 48,
    parameter int              SEQ_W         = 16,
    parameter longint unsigned NOMINAL_TICKS = 64'd50_000_000,
    parameter longint unsigned PPM_TOL       = 64'd100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_valid_i,
    input  logic [TS_W-1:0]  rec_ts_i,
    input  logic [SEQ_W-1:0] rec_seq_i,
    output logic             lock_o,
    output logic [TS_W-1:0]  interval_o
);

    localparam longint unsigned BAND   = pps_pkg::band_ticks(NOMINAL_TICKS, PPM_TOL);
    localparam logic [63:0]     LO_LIM = 64'(NOMINAL_TICKS - BAND);
    localparam logic [63:0]     HI_LIM = 64'(NOMINAL_TICKS + BAND);

    logic [TS_W-1:0]  prev_ts_q;
    logic [SEQ_W-1:0] prev_seq_q;
    logic             have_prev_q;
    logic             lock_q;
    logic [TS_W-1:0]  interval_q;

    logic [TS_W-1:0]  delta;
    logic [63:0]      delta_wide;
    logic             tag_ok;
    logic             in_band;

    // Wrap-safe distance: modular subtraction over the timestamp width.
    always_comb begin
        delta      = rec_ts_i - prev_ts_q;
        delta_wide = 64'(delta);
        tag_ok     = have_prev_q && (rec_seq_i == prev_seq_q + SEQ_W'(1));
        in_band    = (delta_wide >= LO_LIM) && (delta_wide <= HI_LIM);
    end

    // Remembers the latest record as the reference for the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ts_q   <= '0;
            prev_seq_q  <= '0;
            have_prev_q <= 1'b0;
        end else if (rec_valid_i) begin
            prev_ts_q   <= rec_ts_i;
            prev_seq_q  <= rec_seq_i;
            have_prev_q <= 1'b1;
        end
    end

    // Judges a qualified interval: inside the band locks and loads it, outside unlocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q     <= 1'b0;
            interval_q <= '0;
        end else if (rec_valid_i && tag_ok) begin
            if (in_band) begin
                lock_q     <= 1'b1;
                interval_q <= delta;
            end else begin
                lock_q     <= 1'b0;
            end
        end
    end

    assign lock_o     = lock_q;
    assign interval_o = interval_q;

    // R8: lock is only gained with an interval inside the band.
    p_lock_band_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> (64'(interval_o) >= LO_LIM) && (64'(interval_o) <= HI_LIM));

    // R8: the latched interval moves only on a record.
    p_interval_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_valid_i |=> $stable(interval_o));

    // R7: a record without a predecessor leaves lock alone.
    p_first_rec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid_i && !have_prev_q) |=> $stable(lock_o));

endmodule

// File: rtl/pps_stamp_unit.sv
// Top: synchroniser, extended counter, capture register and interval qualifier.
// Assumes: one clock domain (base oscillator); pps_in is asynchronous.
module pps_stamp_unit #(
    parameter int              CNT_W         = 32,
    parameter int              OVF_W         = 16,
    parameter int              SEQ_W         = 16,
    parameter int              SYNC_STAGES   = 2,
    parameter longint unsigned NOMINAL_TICKS = 64'd50_000_000,
    parameter longint unsigned PPM_TOL       = 64'd100
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pps_in,
    input  logic                         rd_ack,
    output logic                         rec_valid,
    output logic [SEQ_W+OVF_W+CNT_W-1:0] rec_data,
    output logic                         ready,
    output logic                         lock,
    output logic [OVF_W+CNT_W-1:0]       interval_ticks
);

    localparam int TS_W = CNT_W + OVF_W;

    logic             pulse_edge;
    logic [TS_W-1:0]  now_ts;
    logic [TS_W-1:0]  cap_ts;
    logic [SEQ_W-1:0] cap_seq;

    pps_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (pps_in),
        .edge_o  (pulse_edge)
    );

    pps_ext_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .ts_o  (now_ts)
    );

    pps_capture #(.TS_W(TS_W), .SEQ_W(SEQ_W)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_i      (pulse_edge),
        .ts_i        (now_ts),
        .rd_ack_i    (rd_ack),
        .rec_valid_o (rec_valid),
        .rec_ts_o    (cap_ts),
        .rec_seq_o   (cap_seq),
        .ready_o     (ready)
    );

    pps_interval_qual #(
        .TS_W          (TS_W),
        .SEQ_W         (SEQ_W),
        .NOMINAL_TICKS (NOMINAL_TICKS),
        .PPM_TOL       (PPM_TOL)
    ) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .rec_valid_i (rec_valid),
        .rec_ts_i    (cap_ts),
        .rec_seq_i   (cap_seq),
        .lock_o      (lock),
        .interval_o  (interval_ticks)
    );

    // R4: tag occupies the upper bits of the record.
    assign rec_data = {cap_seq, cap_ts};

    // R3: a record strobe is never two cycles long.
    p_rec_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid);

endmodule

// File: tb/pps_stamp_unit_bench.sv
// Self-checking bench on a small configuration: 10-bit counter, 6-bit wrap count, 3-bit tag.
module pps_stamp_unit_bench;

    localparam int              CNT_W = 10;
    localparam int              OVF_W = 6;
    localparam int              SEQ_W = 3;
    localparam int              TS_W  = CNT_W + OVF_W;
    localparam int              REC_W = SEQ_W + TS_W;
    localparam longint unsigned NOM   = 64'd20000;
    localparam longint unsigned PPM   = 64'd100;
    localparam longint          BAND  = longint'((NOM * PPM) / 64'd1_000_000);
    localparam longint          LO    = longint'(NOM) - BAND;
    localparam longint          HI    = longint'(NOM) + BAND;
    localparam longint          TSMOD = longint'(1) << TS_W;
    localparam longint          SQMOD = longint'(1) << SEQ_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pps_in = 1'b0;
    logic             rd_ack = 1'b0;
    logic             rec_valid;
    logic [REC_W-1:0] rec_data;
    logic             ready;
    logic             lock;
    logic [TS_W-1:0]  interval_ticks;

    int     n_chk = 0;
    int     n_err = 0;
    int     n_rec = 0;
    bit     done  = 1'b0;
    longint cyc   = 0;

    // Reference model of the judging logic.
    bit     m_have = 1'b0;
    longint m_prev = 0;
    bit     m_lock = 1'b0;
    longint m_int  = 0;
    int     m_n    = 0;

    pps_stamp_unit #(
        .CNT_W(CNT_W), .OVF_W(OVF_W), .SEQ_W(SEQ_W),
        .SYNC_STAGES(2), .NOMINAL_TICKS(NOM), .PPM_TOL(PPM)
    ) u_pps_stamp_unit (
        .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .rd_ack(rd_ack),
        .rec_valid(rec_valid), .rec_data(rec_data), .ready(ready),
        .lock(lock), .interval_ticks(interval_ticks)
    );

    always #2.5 clk = ~clk;

    // Clocks since reset, the same count the timestamp should follow.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Counts record strobes.
    always @(posedge clk) if (rst_n && rec_valid) n_rec <= n_rec + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Places a pulse so that its capture lands on tick T, then checks record, ready and lock.
    task automatic capture_at(input longint T, input int width, input bit ack_same);
        longint exp_rec;
        longint d;
        while (cyc != T - 2) @(negedge clk);
        pps_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (ack_same) rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        m_n++;
        exp_rec = ((longint'(m_n) % SQMOD) << TS_W) | (T % TSMOD);
        check(rec_valid == 1'b1, "R3", "rec_valid on capture", longint'(rec_valid), 1);
        check(64'(rec_data) == exp_rec, "R4", "record {tag,ts}", longint'(rec_data), exp_rec);
        check(ready == 1'b1, "R9", "ready after capture", longint'(ready), 1);
        if (m_have) begin
            d = (T - m_prev) % TSMOD;
            if (d >= LO && d <= HI) begin
                m_lock = 1'b1;
                m_int  = d;
            end else begin
                m_lock = 1'b0;
            end
        end
        m_have = 1'b1;
        m_prev = T;
        @(negedge clk);
        check(rec_valid == 1'b0, "R3", "strobe is one cycle", longint'(rec_valid), 0);
        check(lock == m_lock, "R8", "lock after judge", longint'(lock), longint'(m_lock));
        check(64'(interval_ticks) == m_int, "R6", "interval", longint'(interval_ticks), m_int);
        repeat (width) @(negedge clk);
        pps_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(rec_valid == 1'b0, "R10", "rec_valid in reset", longint'(rec_valid), 0);
        check(rec_data == '0, "R10", "rec_data in reset", longint'(rec_data), 0);
        check(ready == 1'b0, "R10", "ready in reset", longint'(ready), 0);
        check(lock == 1'b0, "R10", "lock in reset", longint'(lock), 0);
        check(interval_ticks == '0, "R10", "interval in reset", longint'(interval_ticks), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b0 && lock == 1'b0, "R10", "idle after reset",
              longint'({ready, lock}), 0);

        // R5 and R7: first capture on counter all-ones, long pulse, no lock yet
        capture_at(64'd1023, 60, 1'b0);
        check(lock == 1'b0, "R7", "first record leaves lock", longint'(lock), 0);
        // R9: read strobe clears ready
        repeat (5) @(negedge clk);
        check(ready == 1'b1, "R9", "ready held until read", longint'(ready), 1);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        check(ready == 1'b0, "R9", "ready cleared by read", longint'(ready), 0);

        capture_at(64'd21023, 4, 1'b0);      // nominal, R8 lock set
        capture_at(64'd41025, 4, 1'b1);      // upper bound, read in same cycle (R9)
        capture_at(64'd61028, 4, 1'b0);      // one above, R8 unlock
        capture_at(64'd81026, 4, 1'b0);      // lower bound across timestamp wrap (R6)
        capture_at(64'd101023, 4, 1'b0);     // one below
        capture_at(64'd122880, 4, 1'b0);     // counter zero right after a roll (R5)
        capture_at(64'd142880, 4, 1'b0);     // tag wraps to 0, still qualified (R7)
        capture_at(64'd162882, 4, 1'b0);     // tag 1 after wrap, upper bound

        // R3: one record per rising edge, whatever the pulse width
        check(n_rec == 9, "R3", "record count", longint'(n_rec), 9);
        check(lock == 1'b1, "R8", "final lock", longint'(lock), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R3 watchdog expired actual=%0d expected=%0d", n_rec, 9);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule